// File: doc/BRIEF.md
# Hit-under-miss data cache controller

This block is a direct-mapped data cache controller placed between a load/store request port and two memories. Cacheable memory sits behind an external bus that takes commands and returns line fills one word per beat. Uncached memory has a separate port with a one-cycle read latency. The controller tracks a single outstanding line fill. While that fill is in flight, loads that hit in the cache and all uncached accesses keep completing without stalling. A second cacheable load miss is held at the port until the running fill has finished, and its own fill starts as soon as it is released.

Stores to cacheable addresses are write-through and never allocate a line. A store that hits updates the cached word, and every cacheable store is sent out as a bus write. Cacheable stores need the external bus, so they wait while a fill owns it. A load that missed gets its word on the cycle after the last fill beat. Loads that hit and uncached loads get their data on the cycle after they are accepted.

Top module: `hum_dcache`

## Requirements
- R1: A cacheable load (address bit 31 clear) that hits returns its word with `rsp_valid` high on the cycle after acceptance. This holds even while a fill is running, and such a load never raises `req_stall` except in the final-beat cycle (R10).
- R2: A cacheable load that misses while no fill is running is accepted without stall. On the next cycle it produces a single bus command with `bus_write` = 0 and `bus_addr` set to the line-aligned address (low 4 bits zero for 4-word lines).
- R3: Fill beats fill words 0, 1, 2 and 3 of the line, in that order. The line becomes valid only after the last beat. The missed load receives the word at its own offset, with `rsp_valid`, on the cycle after the last beat.
- R4: Only one fill is ever outstanding. A cacheable load miss that arrives during a fill holds `req_stall` high until the first cycle after the last beat. It is accepted in that cycle, and its fill command follows on the next cycle.
- R5: A request to the line index currently being filled counts as a miss, even when the tag matches the incoming line, so it stalls until the fill completes.
- R6: An uncached access (address bit 31 set) drives `nc_valid`, `nc_write`, `nc_addr` and `nc_wdata` in the cycle it is accepted. It never stalls during a fill. An uncached load returns `nc_rdata` with `rsp_valid` on the next cycle.
- R7: A cacheable store hit, with no fill running, updates the cached word, so later loads return the new value. It issues a bus write (`bus_write` = 1) with its address and data on the next cycle and produces no response.
- R8: A cacheable store miss issues a bus write and starts no fill. A later load to that line is still a miss.
- R9: A cacheable store, whether hit or miss, that arrives during a fill stalls until the first cycle after the last beat.
- R10: In the cycle where the last fill beat arrives, every request stalls for that one cycle. This leaves the response slot free for the missed load.
- R11: After reset, no line is valid, no fill is running, and `rsp_valid`, `bus_valid` and `req_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held while stalled |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address; bit 31 selects uncached |
| req_wdata | input | 32 | Store data |
| req_stall | output | 1 | Request not accepted this cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| bus_valid | output | 1 | External bus command pulse |
| bus_write | output | 1 | 1 = write-through store, 0 = line fill request |
| bus_addr | output | 32 | Store address or line-aligned fill address |
| bus_wdata | output | 32 | Store data |
| bus_rvalid | input | 1 | Fill beat strobe |
| bus_rdata | input | 32 | Fill beat word |
| nc_valid | output | 1 | Uncached access strobe |
| nc_write | output | 1 | Uncached store |
| nc_addr | output | 32 | Uncached address |
| nc_wdata | output | 32 | Uncached store data |
| nc_rdata | input | 32 | Uncached read data, one cycle after the strobe |

## Verification
The bench builds the block with its defaults of 16 lines and 4 words per line. With 16 lines, address 0x700 maps to the same index as 0x100 but carries a different tag, so eviction and stale-line misses can be reached. The fill responder waits five cycles after each command before sending its four beats. That window is long enough to place hits, uncached accesses and a second miss inside a running fill. A continuous stream of hits is then pushed across a fill so that exactly one of them falls on the final-beat cycle.

// File: rtl/hum_pkg.sv
package hum_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BYTE_W    = 2;
    localparam int unsigned DEF_LINES = 16;
    localparam int unsigned DEF_WORDS = 4;

    typedef enum logic {
        FILL_IDLE,
        FILL_RUN
    } fill_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CACHE,
        SRC_UNCACHED,
        SRC_FILL
    } rsp_src_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic logic is_uncached(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic logic [ADDR_W-1:0] line_align(input logic [ADDR_W-1:0] a,
                                                     input int unsigned line_bytes);
        logic [ADDR_W-1:0] mask;
        mask = ADDR_W'(line_bytes - 1);
        return a & ~mask;
    endfunction

endpackage

// File: rtl/hum_tag_array.sv
module hum_tag_array #(
    parameter int unsigned LINES = 16,
    parameter int unsigned TAG_W = 23,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);

    logic [LINES-1:0] vld;
    logic [TAG_W-1:0] tags [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (inv_en) vld[inv_idx] <= 1'b0;
            if (set_en) vld[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tags[set_idx] <= set_tag;
    end

    assign lk_hit = vld[lk_idx] && (tags[lk_idx] == lk_tag);

    // R4: invalidation at fill start and validation at fill end never coincide
    a_r4_inv_set_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(inv_en && set_en));

    // R3: the line becomes valid right after its last beat
    a_r3_valid_after_last: assert property (@(posedge clk) disable iff (rst)
        set_en |=> vld[$past(set_idx)]);

    // R5: a line being refilled is not valid until the fill closes
    a_r5_invalid_after_start: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> !vld[$past(inv_idx)]);

endmodule

// File: rtl/hum_line_store.sv
module hum_line_store #(
    parameter int unsigned LINES  = 16,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [OFF_W-1:0]  fill_off,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [OFF_W-1:0]  st_off,
    input  logic [DATA_W-1:0] st_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [LINES][WORDS];

    generate
        for (genvar li = 0; li < LINES; li++) begin : g_line
            for (genvar wi = 0; wi < WORDS; wi++) begin : g_word
                always_ff @(posedge clk) begin
                    if (fill_we && fill_idx == IDX_W'(li) && fill_off == OFF_W'(wi))
                        words[li][wi] <= fill_data;
                    else if (st_we && st_idx == IDX_W'(li) && st_off == OFF_W'(wi))
                        words[li][wi] <= st_data;
                end
            end
        end
    endgenerate

    assign rd_data = words[rd_idx][rd_off];

    // R9: no store may write the array while a fill beat lands
    a_r9_no_store_during_beat: assert property (@(posedge clk) disable iff (rst)
        !(fill_we && st_we));

endmodule

// File: rtl/hum_fill_ctl.sv
module hum_fill_ctl
    import hum_pkg::*;
#(
    parameter int unsigned WORDS  = 4,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned TAG_W  = 23,
    localparam int unsigned OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [OFF_W-1:0]  start_off,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic              beat_we,
    output logic [OFF_W-1:0]  beat_off,
    output logic              last,
    output logic [DATA_W-1:0] miss_data
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    fill_state_e       state;
    logic [OFF_W-1:0]  cnt;
    logic [OFF_W-1:0]  want_off;
    logic [DATA_W-1:0] cap;

    assign busy     = (state == FILL_RUN);
    assign beat_we  = busy && beat_valid;
    assign beat_off = cnt;
    assign last     = beat_we && (cnt == LAST_OFF);
    assign miss_data = (cnt == want_off) ? beat_data : cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FILL_IDLE;
            cnt      <= '0;
            want_off <= '0;
            idx      <= '0;
            tag      <= '0;
            cap      <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        state    <= FILL_RUN;
                        cnt      <= '0;
                        idx      <= start_idx;
                        tag      <= start_tag;
                        want_off <= start_off;
                    end
                end
                FILL_RUN: begin
                    if (beat_we) begin
                        if (cnt == want_off) cap <= beat_data;
                        cnt <= cnt + 1'b1;
                        if (last) state <= FILL_IDLE;
                    end
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    // R4: a new fill is only launched from idle
    a_r4_single_fill: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R4: after the last beat the sequencer is free again
    a_r4_free_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);

    // R3: beats between start and last advance one word at a time
    a_r3_beat_order: assert property (@(posedge clk) disable iff (rst)
        (beat_we && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/hum_dcache.sv
module hum_dcache
    import hum_pkg::*;
#(
    parameter int unsigned LINES = DEF_LINES,
    parameter int unsigned WORDS = DEF_WORDS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        req_stall,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        bus_valid,
    output logic        bus_write,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_rvalid,
    input  logic [31:0] bus_rdata,
    output logic        nc_valid,
    output logic        nc_write,
    output logic [31:0] nc_addr,
    output logic [31:0] nc_wdata,
    input  logic [31:0] nc_rdata
);

    localparam int unsigned IDX_W      = $clog2(LINES);
    localparam int unsigned OFF_W      = $clog2(WORDS);
    localparam int unsigned LINE_BYTES = WORDS * (DATA_W / 8);
    localparam int unsigned IDX_LSB    = BYTE_W + OFF_W;
    localparam int unsigned TAG_LSB    = IDX_LSB + IDX_W;
    localparam int unsigned TAG_W      = ADDR_W - 1 - TAG_LSB;

    // request decode
    logic             uncached;
    logic [IDX_W-1:0] rq_idx;
    logic [OFF_W-1:0] rq_off;
    logic [TAG_W-1:0] rq_tag;
    logic             lk_hit;

    assign uncached = is_uncached(req_addr);
    assign rq_idx   = req_addr[IDX_LSB +: IDX_W];
    assign rq_off   = req_addr[BYTE_W +: OFF_W];
    assign rq_tag   = req_addr[ADDR_W-2:TAG_LSB];

    // fill sequencer wires
    logic              fill_busy;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              beat_we;
    logic [OFF_W-1:0]  beat_off;
    logic              fill_last;
    logic [DATA_W-1:0] miss_data;
    logic [DATA_W-1:0] rd_data;

    // port control
    logic accept;
    logic fill_start;
    logic store_hit_we;

    assign req_stall = req_valid &&
                       (fill_last || (fill_busy && !uncached && (req_write || !lk_hit)));
    assign accept       = req_valid && !req_stall;
    assign fill_start   = accept && !uncached && !req_write && !lk_hit;
    assign store_hit_we = accept && !uncached && req_write && lk_hit;

    hum_tag_array #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (rq_idx),
        .lk_tag  (rq_tag),
        .lk_hit  (lk_hit),
        .inv_en  (fill_start),
        .inv_idx (rq_idx),
        .set_en  (fill_last),
        .set_idx (fill_idx),
        .set_tag (fill_tag)
    );

    hum_line_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk       (clk),
        .rst       (rst),
        .fill_we   (beat_we),
        .fill_idx  (fill_idx),
        .fill_off  (beat_off),
        .fill_data (bus_rdata),
        .st_we     (store_hit_we),
        .st_idx    (rq_idx),
        .st_off    (rq_off),
        .st_data   (req_wdata),
        .rd_idx    (rq_idx),
        .rd_off    (rq_off),
        .rd_data   (rd_data)
    );

    hum_fill_ctl #(
        .WORDS (WORDS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .start      (fill_start),
        .start_idx  (rq_idx),
        .start_tag  (rq_tag),
        .start_off  (rq_off),
        .beat_valid (bus_rvalid),
        .beat_data  (bus_rdata),
        .busy       (fill_busy),
        .idx        (fill_idx),
        .tag        (fill_tag),
        .beat_we    (beat_we),
        .beat_off   (beat_off),
        .last       (fill_last),
        .miss_data  (miss_data)
    );

    // uncached port: passes the accepted request straight through
    assign nc_valid = req_valid && uncached && !req_stall;
    assign nc_write = req_write;
    assign nc_addr  = req_addr;
    assign nc_wdata = req_wdata;

    // response slot
    rsp_src_e          src_q;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_NONE;
            word_q <= '0;
        end else if (fill_last) begin
            src_q  <= SRC_FILL;
            word_q <= miss_data;
        end else if (accept && !req_write && uncached) begin
            src_q  <= SRC_UNCACHED;
        end else if (accept && !req_write && lk_hit) begin
            src_q  <= SRC_CACHE;
            word_q <= rd_data;
        end else begin
            src_q  <= SRC_NONE;
        end
    end

    assign rsp_valid = (src_q != SRC_NONE);
    assign rsp_rdata = (src_q == SRC_UNCACHED) ? nc_rdata : word_q;

    // external bus command
    bus_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (fill_start) begin
            cmd_q <= '{valid: 1'b1, write: 1'b0,
                       addr: line_align(req_addr, LINE_BYTES), data: '0};
        end else if (accept && req_write && !uncached) begin
            cmd_q <= '{valid: 1'b1, write: 1'b1, addr: req_addr, data: req_wdata};
        end else begin
            cmd_q.valid <= 1'b0;
        end
    end

    assign bus_valid = cmd_q.valid;
    assign bus_write = cmd_q.write;
    assign bus_addr  = cmd_q.addr;
    assign bus_wdata = cmd_q.data;

    // R1: an accepted load hit answers on the next cycle
    a_r1_hit_answers: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && !uncached && lk_hit) |=> rsp_valid);

    // R2: a launched fill shows up as a read command next cycle
    a_r2_fill_cmd: assert property (@(posedge clk) disable iff (rst)
        fill_start |=> (bus_valid && !bus_write));

    // R4: a cacheable miss during a fill is held at the port
    a_r4_second_miss_stalls: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fill_busy && !uncached && !lk_hit) |-> req_stall);

    // R6: uncached requests reach their port whenever they are accepted
    a_r6_uncached_strobe: assert property (@(posedge clk) disable iff (rst)
        (accept && uncached) |-> (nc_valid && !bus_valid_next_fill));

    logic bus_valid_next_fill;
    assign bus_valid_next_fill = fill_start;

    // R9: cacheable stores never pass while the fill owns the bus
    a_r9_store_waits: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !uncached && fill_busy) |-> req_stall);

    // R10: the final-beat cycle hands its response slot to the missed load
    a_r10_fill_slot: assert property (@(posedge clk) disable iff (rst)
        fill_last |=> (rsp_valid && $past(!accept)));

    // R11: reset leaves no response and no bus command
    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !bus_valid));

endmodule

// File: tb/tb_hum_dcache.sv
module tb_hum_dcache;

    localparam int CLK_P = 10;
    localparam int GAP   = 5;
    localparam int WDOG  = 20000;
    localparam logic [31:0] NC_PAT = 32'hC3C3_0000;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        int          due;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_stall;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_valid;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        nc_valid;
    logic        nc_write;
    logic [31:0] nc_addr;
    logic [31:0] nc_wdata;
    logic [31:0] nc_rdata = '0;

    hum_dcache dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_stall(req_stall),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .nc_valid(nc_valid), .nc_write(nc_write), .nc_addr(nc_addr),
        .nc_wdata(nc_wdata), .nc_rdata(nc_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    exp_t rsp_q[$];
    exp_t fill_q[$];
    exp_t wr_q[$];
    logic        pend_valid = 1'b0;
    logic [31:0] pend_data  = '0;
    int          last_due   = -1;

    logic [31:0] mem_model [logic [31:0]];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // uncached memory: one-cycle read latency
    always @(posedge clk) if (nc_valid) nc_rdata <= nc_addr ^ NC_PAT;

    // fill responder for the external bus
    initial begin
        forever begin
            @(negedge clk);
            if (bus_valid && !bus_write) begin
                logic [31:0] line;
                line = bus_addr;
                repeat (GAP) @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    bus_rvalid = 1'b1;
                    bus_rdata  = mem_rd(line + 32'(4 * k));
                    if (k == 3) last_due = cyc + 1;
                    @(negedge clk);
                end
                bus_rvalid = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (pend_valid && cyc == last_due) begin
                    check(rsp_rdata == pend_data, "R3 miss data", rsp_rdata, pend_data);
                    pend_valid = 1'b0;
                end else if (rsp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected response", rsp_rdata, 32'h0);
                end else begin
                    exp_t e;
                    e = rsp_q.pop_front();
                    check(cyc == e.due, "R1 response cycle", 32'(cyc), 32'(e.due));
                    check(rsp_rdata == e.d, "R1 response data", rsp_rdata, e.d);
                end
            end
            if (!rst && bus_valid) begin
                if (!bus_write) begin
                    if (fill_q.size() == 0) begin
                        check(1'b0, "R8 unexpected fill", bus_addr, 32'h0);
                    end else begin
                        exp_t e;
                        e = fill_q.pop_front();
                        check(bus_addr == e.a && cyc == e.due, "R2 fill command",
                              bus_addr, e.a);
                    end
                end else begin
                    if (wr_q.size() == 0) begin
                        check(1'b0, "R7 unexpected bus write", bus_addr, 32'h0);
                    end else begin
                        exp_t e;
                        e = wr_q.pop_front();
                        check(bus_addr == e.a && bus_wdata == e.d && cyc == e.due,
                              "R7 bus write", bus_wdata, e.d);
                    end
                end
            end
        end
    end

    // one request through the port; returns stall count and acceptance cycle
    task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         output int stalls, output int acc_c);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        stalls    = 0;
        forever begin
            #(CLK_P/4);
            if (!req_stall) break;
            stalls++;
            @(negedge clk);
        end
        acc_c = cyc;
        if (a[31]) begin
            check(nc_valid && nc_write == wr && nc_addr == a && nc_wdata == d,
                  "R6 uncached pins", nc_addr, a);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic stall_check(input int mode, input int st, input int c, input string req);
        if (mode == 0) check(st == 0, req, 32'(st), 32'h0);
        if (mode == 1) check(st > 0 && c == last_due, req, 32'(c), 32'(last_due));
    endtask

    // kind: 0 hit, 1 miss, 2 uncached; mode: 0 no stall, 1 released after fill, 2 free
    task automatic load(input logic [31:0] a, input int kind, input int mode,
                        input string req);
        int st;
        int c;
        exp_t e;
        issue(1'b0, a, 32'h0, st, c);
        stall_check(mode, st, c, req);
        e.a = a;
        e.due = c + 1;
        if (kind == 2) begin
            e.d = a ^ NC_PAT;
            rsp_q.push_back(e);
        end else if (kind == 0) begin
            e.d = mem_rd(a);
            rsp_q.push_back(e);
        end else begin
            pend_data  = mem_rd(a);
            pend_valid = 1'b1;
            e.a = a & ~32'hF;
            fill_q.push_back(e);
        end
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input int mode,
                         input string req);
        int st;
        int c;
        exp_t e;
        issue(1'b1, a, d, st, c);
        stall_check(mode, st, c, req);
        if (!a[31]) begin
            mem_model[a] = d;
            e.a = a;
            e.d = d;
            e.due = c + 1;
            wr_q.push_back(e);
        end
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    task automatic run_all();
        int total;
        int st;
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: quiet after reset
        check(!rsp_valid, "R11 rsp_valid after reset", 32'(rsp_valid), 32'h0);
        check(!bus_valid, "R11 bus_valid after reset", 32'(bus_valid), 32'h0);
        check(!req_stall, "R11 req_stall after reset", 32'(req_stall), 32'h0);

        // R2 / R6 / R5: first miss, uncached traffic during it, same-line request
        load(32'h0000_0108, 1, 0, "R2 first miss no stall");
        load(32'h8000_0040, 2, 0, "R6 uncached load during fill");
        store(32'h8000_0044, 32'h1234_5678, 0, "R6 uncached store during fill");
        load(32'h0000_0104, 0, 1, "R5 same line waits for fill");
        settle();

        // R1 / R4: hits during a fill, second miss held, hits during second fill
        load(32'h0000_0324, 1, 0, "R2 miss offset 1");
        load(32'h0000_010C, 0, 0, "R1 hit during fill");
        load(32'h0000_0100, 0, 0, "R1 hit during fill word 0");
        load(32'h0000_0430, 1, 1, "R4 second miss released after fill");
        load(32'h0000_0108, 0, 0, "R1 hit during second fill");
        load(32'h0000_0328, 0, 0, "R1 hit on freshly filled line");
        settle();

        // R3: missed word is the last beat of the line
        load(32'h0000_053C, 1, 0, "R3 miss on last word");
        settle();
        load(32'h0000_0534, 0, 0, "R3 rest of line valid");

        // R7: store hit updates the cache and writes through
        store(32'h0000_0104, 32'hDEAD_0001, 0, "R7 store hit no stall");
        load(32'h0000_0104, 0, 0, "R7 load sees stored word");
        settle();

        // R8: store miss does not allocate
        store(32'h0000_061C, 32'hBEEF_0002, 0, "R8 store miss no stall");
        load(32'h0000_061C, 1, 0, "R8 line still misses");
        settle();

        // R9: cacheable store during a fill; index aliasing evicts 0x100 line
        load(32'h0000_0700, 1, 0, "R2 miss aliasing index 0");
        store(32'h0000_0328, 32'hCAFE_0003, 1, "R9 store waits for fill");
        load(32'h0000_0328, 0, 0, "R9 stored word visible");
        load(32'h0000_0108, 1, 0, "R5 evicted line misses");
        settle();

        // R10: hit stream across a fill stalls exactly once
        load(32'h0000_0840, 1, 0, "R2 miss before hit stream");
        total = 0;
        for (int i = 0; i < 14; i++) begin
            issue(1'b0, 32'h0000_0328, 32'h0, st, c);
            total += st;
            begin
                exp_t e;
                e.a = 32'h0000_0328;
                e.d = mem_rd(32'h0000_0328);
                e.due = c + 1;
                rsp_q.push_back(e);
            end
        end
        check(total == 1, "R10 one stall on final beat", 32'(total), 32'h1);
        settle();

        check(rsp_q.size() == 0 && !pend_valid, "R1 all responses seen",
              32'(rsp_q.size()), 32'h0);
        check(fill_q.size() == 0, "R2 all fills seen", 32'(fill_q.size()), 32'h0);
        check(wr_q.size() == 0, "R7 all bus writes seen", 32'(wr_q.size()), 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WDOG) @(posedge clk);
                check(1'b0, "watchdog expired", 32'(cyc), 32'h0);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule